// File: doc/BRIEF.md
# Sampled-Audio Record/Playback Sequencer

This block sequences a small audio recorder made of an external 8-bit successive-approximation converter, a byte-wide RAM and a DAC that monitors the shared data bus. The block does not carry the data. It drives the control strobes that decide who owns the bus. It also drives the RAM address and tracks whether the recorder is capturing or replaying.

While capturing, each accepted sample tick starts a conversion. The block then waits for the converter's active-low completion line and turns on the converter's outputs. It pulses the RAM write strobe inside that read window, so the sample lands at the current address. While replaying, the RAM output enable is held active and the address steps on each tick, so the DAC sees the stored samples again. The converter strobes stay quiet in this mode.

A full pass over the address space flips the mode. A conversion that never completes raises a sticky timeout flag, and the slot is dropped without a write.

Top module: `rec_play_seq`

## Requirements
- R1: After synchronous reset the block is capturing (`play_mode`=0) at address 0. `adc_start_n`, `adc_rd_n`, `ram_we_n` and `ram_oe_n` are all high, and `conv_timeout` is 0.
- R2: Each accepted tick while capturing drives `adc_start_n` low for exactly STRB_CYC clock cycles and then raises it. Only one start pulse is made per tick.
- R3: `ram_we_n` goes low only after `adc_done_n` has gone low and while `adc_rd_n` is low. It stays low for WE_CYC cycles and rises while `adc_rd_n` is still low.
- R4: While replaying (`play_mode`=1), `adc_start_n`, `adc_rd_n` and `ram_we_n` stay high and `ram_oe_n` stays low.
- R5: While capturing, `ram_oe_n` stays high.
- R6: The first accepted tick after reset uses address 0. Every later accepted tick adds 1 to `ram_addr`, and the largest address wraps to 0.
- R7: The accepted tick that wraps the address toggles `play_mode`. A capture slot starts at address 0 when the wrap enters capture mode, and none starts when it enters replay.
- R8: A tick that arrives while a capture slot is still running is ignored. The address does not change and no extra start pulse is made.
- R9: If the completion line is not low within TMO_CYC cycles after the start strobe rises, `conv_timeout` goes to 1 and stays set until reset. That slot makes no read and no write, and the next tick is accepted.
- R10: Over one capture sweep each address is written once with the sample of its own slot. The following replay sweep presents those samples in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_tick | input | 1 | One-cycle sample pacing pulse |
| adc_done_n | input | 1 | Converter completion, active low (synchronised inside) |
| adc_start_n | output | 1 | Converter start strobe; rising edge begins conversion |
| adc_rd_n | output | 1 | Converter output enable onto the bus, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_addr | output | ADDR_W | RAM address |
| play_mode | output | 1 | 0 = capturing, 1 = replaying |
| conv_timeout | output | 1 | Sticky conversion-timeout flag |

## Verification
Two functions can fall on the same cycle. The tick that wraps the address also changes the mode, and when that change enters capture mode it starts a conversion at address 0 on the same edge. The bench drives the wrap in both directions. It judges the result by the address, the mode, and whether a start pulse follows. A second collision is a tick that arrives while a capture slot is still in its handshake. The bench provokes this by ticking again three cycles later, and expects exactly one address step and exactly one start pulse.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_WAIT,
    ST_READ,
    ST_WRITE,
    ST_HOLD
  } seq_state_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/seq_sync2.sv
module seq_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/seq_addr_ctr.sv
module seq_addr_ctr #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  output logic [ADDR_W-1:0] addr,
  output logic              play,
  output logic              go_rec
);
  localparam logic [ADDR_W-1:0] ADDR_MAX = {ADDR_W{1'b1}};

  logic primed;
  logic wrap;

  assign wrap   = accept && primed && (addr == ADDR_MAX);
  assign go_rec = accept && !(play ^ wrap);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      play   <= 1'b0;
      primed <= 1'b0;
    end else if (accept) begin
      primed <= 1'b1;
      if (primed) addr <= addr + 1'b1;
      if (wrap)   play <= ~play;
    end
  end
endmodule

// File: rtl/seq_strobe_fsm.sv
module seq_strobe_fsm
  import seq_pkg::*;
#(
  parameter int STRB_CYC = 4,
  parameter int WE_CYC   = 2,
  parameter int TMO_CYC  = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic done,
  output logic idle,
  output logic start_n,
  output logic rd_n,
  output logic we_n,
  output logic tmo
);
  localparam int CMAX  = max3(STRB_CYC, WE_CYC, TMO_CYC);
  localparam int CNT_W = $clog2(CMAX + 1);
  localparam logic [CNT_W-1:0] STRB_LAST = CNT_W'(STRB_CYC - 1);
  localparam logic [CNT_W-1:0] WE_LAST   = CNT_W'(WE_CYC - 1);
  localparam logic [CNT_W-1:0] TMO_LAST  = CNT_W'(TMO_CYC - 1);

  seq_state_t state, nxt;
  logic [CNT_W-1:0] cnt;
  logic tmo_hit;

  always_comb begin
    nxt     = state;
    tmo_hit = 1'b0;
    unique case (state)
      ST_IDLE:  if (go) nxt = ST_START;
      ST_START: if (cnt == STRB_LAST) nxt = ST_WAIT;
      ST_WAIT: begin
        if (done) nxt = ST_READ;
        else if (cnt == TMO_LAST) begin
          nxt     = ST_IDLE;
          tmo_hit = 1'b1;
        end
      end
      ST_READ:  nxt = ST_WRITE;
      ST_WRITE: if (cnt == WE_LAST) nxt = ST_HOLD;
      ST_HOLD:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      start_n <= 1'b1;
      rd_n    <= 1'b1;
      we_n    <= 1'b1;
      tmo     <= 1'b0;
    end else begin
      state   <= nxt;
      cnt     <= (nxt != state) ? '0 : cnt + 1'b1;
      start_n <= (nxt != ST_START);
      rd_n    <= !(nxt == ST_READ || nxt == ST_WRITE || nxt == ST_HOLD);
      we_n    <= (nxt != ST_WRITE);
      if (tmo_hit) tmo <= 1'b1;
    end
  end

  assign idle = (state == ST_IDLE);
endmodule

// File: rtl/rec_play_seq.sv
module rec_play_seq #(
  parameter int ADDR_W   = 17,
  parameter int STRB_CYC = 4,
  parameter int WE_CYC   = 2,
  parameter int TMO_CYC  = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_tick,
  input  logic              adc_done_n,
  output logic              adc_start_n,
  output logic              adc_rd_n,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              play_mode,
  output logic              conv_timeout
);
  logic done_n_s;
  logic idle;
  logic accept;
  logic go_rec;

  seq_sync2 #(.RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (adc_done_n),
    .q   (done_n_s)
  );

  assign accept = smp_tick && idle;

  seq_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .addr   (ram_addr),
    .play   (play_mode),
    .go_rec (go_rec)
  );

  seq_strobe_fsm #(
    .STRB_CYC (STRB_CYC),
    .WE_CYC   (WE_CYC),
    .TMO_CYC  (TMO_CYC)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .go      (go_rec),
    .done    (!done_n_s),
    .idle    (idle),
    .start_n (adc_start_n),
    .rd_n    (adc_rd_n),
    .we_n    (ram_we_n),
    .tmo     (conv_timeout)
  );

  assign ram_oe_n = !play_mode;
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              adc_start_n,
  input logic              adc_rd_n,
  input logic              ram_we_n,
  input logic              ram_oe_n,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              play_mode,
  input logic              conv_timeout
);
  localparam logic [ADDR_W-1:0] ADDR_MAX = {ADDR_W{1'b1}};

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  AST_PLAY_QUIET: assert property (@(posedge clk) disable iff (rst)
    play_mode |-> (adc_start_n && adc_rd_n && ram_we_n && !ram_oe_n)); // R4

  AST_REC_NO_OE: assert property (@(posedge clk) disable iff (rst)
    !play_mode |-> ram_oe_n); // R5

  AST_WE_IN_RD: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> !adc_rd_n); // R3

  AST_WE_RISE_RD: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $rose(ram_we_n)) |-> !adc_rd_n); // R3

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (past_ok && ram_addr != $past(ram_addr)) |-> ram_addr == ADDR_W'($past(ram_addr) + 1'b1)); // R6

  AST_MODE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (past_ok && play_mode != $past(play_mode)) |-> (ram_addr == '0 && $past(ram_addr) == ADDR_MAX)); // R7

  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(conv_timeout)) |-> conv_timeout); // R9
endmodule

bind rec_play_seq seq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .adc_start_n  (adc_start_n),
  .adc_rd_n     (adc_rd_n),
  .ram_we_n     (ram_we_n),
  .ram_oe_n     (ram_oe_n),
  .ram_addr     (ram_addr),
  .play_mode    (play_mode),
  .conv_timeout (conv_timeout)
);

// File: tb/test_rec_play_seq.sv
`timescale 1ns/1ps
module test_rec_play_seq;
  localparam int AW    = 3;
  localparam int DEPTH = 1 << AW;
  localparam int SC    = 3;
  localparam int WC    = 2;
  localparam int TC    = 40;
  localparam int CONV  = 5;
  localparam int GAP   = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_tick = 1'b0;
  logic adc_done_n = 1'b1;
  logic adc_start_n, adc_rd_n, ram_we_n, ram_oe_n, play_mode, conv_timeout;
  logic [AW-1:0] ram_addr;

  always #2 clk = ~clk;

  rec_play_seq #(.ADDR_W(AW), .STRB_CYC(SC), .WE_CYC(WC), .TMO_CYC(TC)) i_rec_play_seq (
    .clk(clk), .rst(rst), .smp_tick(smp_tick), .adc_done_n(adc_done_n),
    .adc_start_n(adc_start_n), .adc_rd_n(adc_rd_n), .ram_we_n(ram_we_n),
    .ram_oe_n(ram_oe_n), .ram_addr(ram_addr), .play_mode(play_mode),
    .conv_timeout(conv_timeout)
  );

  int checks = 0;
  int errors = 0;

  // converter and RAM models, observed at the falling edge
  logic [7:0] mem [DEPTH];
  logic [7:0] conv_id = 8'd0;
  logic [7:0] bus;
  bit adc_en = 1'b1;
  int conv_timer = 0;
  bit done_seen = 1'b0;
  logic p_start = 1'b1, p_we = 1'b1, p_rd = 1'b1;
  int st_w = 0, last_st_w = 0, we_w = 0, last_we_w = 0;
  int starts = 0, writes = 0, rd_falls = 0;
  int viol_order = 0, viol_play = 0, viol_oe = 0;

  always_comb begin
    if (!adc_rd_n)      bus = conv_id;
    else if (!ram_oe_n) bus = mem[ram_addr];
    else                bus = 8'h00;
  end

  initial for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;

  always @(negedge clk) begin
    if (rst) begin
      p_start = 1'b1; p_we = 1'b1; p_rd = 1'b1; conv_timer = 0; adc_done_n = 1'b1;
    end else begin
      if (!adc_start_n) st_w++;
      if (adc_start_n && !p_start) begin
        last_st_w = st_w; st_w = 0; starts++; conv_id++;
        done_seen = 1'b0;
        conv_timer = adc_en ? CONV : 0;
      end
      if (conv_timer > 0) begin
        conv_timer--;
        if (conv_timer == 0) begin adc_done_n = 1'b0; done_seen = 1'b1; end
      end
      if (!adc_rd_n && p_rd) begin rd_falls++; adc_done_n = 1'b1; end
      if (!ram_we_n) we_w++;
      if (!ram_we_n && p_we && (adc_rd_n || !done_seen)) viol_order++;
      if (ram_we_n && !p_we) begin
        writes++; last_we_w = we_w; we_w = 0;
        if (adc_rd_n) viol_order++;
        mem[ram_addr] = bus;
      end
      if (play_mode && (!adc_start_n || !ram_we_n || !adc_rd_n || ram_oe_n)) viol_play++;
      if (!play_mode && !ram_oe_n) viol_oe++;
      p_start = adc_start_n; p_we = ram_we_n; p_rd = adc_rd_n;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk); smp_tick = 1'b1;
    @(negedge clk); smp_tick = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; smp_tick = 1'b0;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);
    chk(!play_mode && ram_addr == 0, "R1 mode/addr", {play_mode, ram_addr}, 0);
    chk(adc_start_n && adc_rd_n && ram_we_n && ram_oe_n, "R1 strobes high",
        {adc_start_n, adc_rd_n, ram_we_n, ram_oe_n}, 15);
    chk(!conv_timeout, "R1 timeout clear", conv_timeout, 0);
  endtask

  task automatic t_record_sweep();
    int s0, w0;
    for (int i = 0; i < DEPTH; i++) begin
      s0 = starts; w0 = writes;
      pulse_tick();
      wait_cyc(GAP);
      chk(ram_addr == AW'(i), "R6 address step", ram_addr, i);
      chk(starts == s0 + 1 && last_st_w == SC, "R2 start width", last_st_w, SC);
      chk(writes == w0 + 1 && last_we_w == WC, "R3 write width", last_we_w, WC);
      chk(!play_mode, "R5 still capturing", play_mode, 0);
    end
    chk(viol_order == 0, "R3 write inside read window", viol_order, 0);
    chk(viol_oe == 0, "R5 oe high while capturing", viol_oe, 0);
    for (int i = 0; i < DEPTH; i++)
      chk(mem[i] == 8'(i + 1), "R10 stored sample", mem[i], i + 1);
  endtask

  task automatic t_play_sweep();
    int s0, w0;
    s0 = starts; w0 = writes;
    for (int i = 0; i < DEPTH; i++) begin
      pulse_tick();
      wait_cyc(GAP);
      if (i == 0) chk(play_mode && ram_addr == 0, "R7 wrap enters replay", {play_mode, ram_addr}, 8);
      chk(ram_addr == AW'(i), "R6 replay address", ram_addr, i);
      chk(!ram_oe_n && bus == 8'(i + 1), "R10 replay data", bus, i + 1);
    end
    chk(starts == s0 && writes == w0, "R4 no strobes in replay", starts - s0 + writes - w0, 0);
    chk(viol_play == 0, "R4 replay strobe levels", viol_play, 0);
    s0 = starts;
    pulse_tick();
    wait_cyc(GAP);
    chk(!play_mode && ram_addr == 0, "R7 wrap enters capture", {play_mode, ram_addr}, 0);
    chk(starts == s0 + 1, "R7 capture starts at wrap", starts - s0, 1);
  endtask

  task automatic t_busy_tick();
    int s0;
    s0 = starts;
    pulse_tick();
    wait_cyc(3);
    pulse_tick();
    wait_cyc(GAP);
    chk(ram_addr == 1, "R8 busy tick ignored addr", ram_addr, 1);
    chk(starts == s0 + 1, "R8 busy tick no extra start", starts - s0, 1);
  endtask

  task automatic t_timeout();
    int w0, r0;
    w0 = writes; r0 = rd_falls;
    adc_en = 1'b0;
    pulse_tick();
    wait_cyc(SC + TC / 2);
    chk(!conv_timeout, "R9 not early", conv_timeout, 0);
    wait_cyc(TC);
    chk(conv_timeout, "R9 timeout raised", conv_timeout, 1);
    chk(writes == w0 && rd_falls == r0, "R9 no read or write", writes - w0 + rd_falls - r0, 0);
    adc_en = 1'b1;
    pulse_tick();
    wait_cyc(GAP);
    chk(ram_addr == 3 && writes == w0 + 1, "R9 next tick accepted", ram_addr, 3);
    chk(conv_timeout, "R9 flag sticky", conv_timeout, 1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_record_sweep();
    t_play_sweep();
    t_busy_tick();
    t_timeout();
    t_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule